// File: doc/BRIEF.md
# Two-Place Alternating Handshake Buffer

This block is a two-entry FIFO that sits between a producer and a consumer. Both sides use four-phase request/acknowledge handshakes. The input channel is passive and the output channel is active. Words are never shifted from one stage to the next. There are two storage slots, and the block swaps their roles once per phase: one slot is filled from the input while the other is drained to the output. The two transfers of a phase run at the same time. A new phase starts only once both transfers of the current phase have fully returned to idle.

After reset, the block runs a start-up phase. It accepts one word into slot 0 and sends nothing. From then on it alternates:

- One phase receives into slot 1 while sending slot 0.
- The next phase receives into slot 0 while sending slot 1.

Back-pressure follows only from the handshakes, and no full or empty flag exists:

- A consumer that holds off its acknowledge stalls the next input acknowledge.
- A producer that holds off its request stalls the next output request.

The data path is 8 bits wide by default.

Top module: `pphs_buffer`

## Requirements
- R1: During and right after reset, `in_ack` and `out_req` are 0 and `out_data` is 0, because both slots are cleared.
- R2: The input is passive four-phase. `in_ack` rises only after `in_req` was high and the word on `in_data` has been captured, so later changes of `in_data` do not alter the stored word. `in_ack` stays high while `in_req` stays high. `in_ack` falls in the cycle after `in_req` is seen low.
- R3: After reset, no output request is raised until the first input handshake has fully completed. That first word is the first one sent out.
- R4: The output is active four-phase. `out_req` stays high until `out_ack` is seen high and then drops one cycle later. It stays low while `out_ack` remains high. It rises only when `out_ack` was low in the previous cycle.
- R5: `out_data` is stable for at least one cycle before `out_req` rises, and it does not change while `out_req` is high.
- R6: Words leave in exactly the order they arrived, with every value from 0 to 255 carried unchanged.
- R7: A phase ends only when both of its handshakes are complete. While the output handshake is stalled, a second pending input request is not acknowledged. While the input is idle, the next output request is not raised.
- R8: Under any mix of producer gaps and consumer stalls, no word is lost or duplicated.
- R9: A reset in mid-transfer clears both slots and the slot selector and restarts with the start-up phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 1 | Input channel request from the producer |
| in_ack | output | 1 | Input channel acknowledge to the producer |
| in_data | input | DATA_W | Input word, valid while `in_req` is high |
| out_req | output | 1 | Output channel request to the consumer |
| out_ack | input | 1 | Output channel acknowledge from the consumer |
| out_data | output | DATA_W | Output word, bundled with `out_req` |

## Verification
The bench goes after four corner cases.

- **Data capture.** After the acknowledge, it scrambles the input word while the request is still high. A design that acknowledged before capturing, or kept sampling the data, would send out the scrambled value.
- **Phase interlock.** It stalls the consumer while a third word is pending, then starves the input after a drain. A design that let either side run ahead would acknowledge early or raise a request with stale data.
- **Reset mid-transfer.** It resets while a transfer is in flight. A design that left a slot or the selector uncleared would show old data, or skip the start-up phase.
- **Long mixed traffic.** It runs a long stream with varied gaps and stalls, including the values 0x00 and 0xFF. A slot-selection error would show up as a reordered or repeated word.

// File: rtl/pphs_pkg.sv
package pphs_pkg;

  localparam int unsigned SLOT_COUNT = 2;

  // Passive input channel: wait for a request, hold the acknowledge, then
  // park until the phase advances.
  typedef enum logic [1:0] {
    IN_WAIT = 2'd0,
    IN_ACK  = 2'd1,
    IN_DONE = 2'd2
  } in_state_e;

  // Active output channel: data settles one cycle, request, release, park.
  typedef enum logic [1:0] {
    OUT_DONE  = 2'd0,
    OUT_SETUP = 2'd1,
    OUT_REQ   = 2'd2,
    OUT_REL   = 2'd3
  } out_state_e;

endpackage

// File: rtl/pphs_in_port.sv
module pphs_in_port
  import pphs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic in_req,
  output logic in_ack,
  output logic cap,
  output logic done
);

  in_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      IN_WAIT: if (in_req)  st_d = IN_ACK;
      IN_ACK:  if (!in_req) st_d = IN_DONE;
      IN_DONE: if (go)      st_d = IN_WAIT;
      default:              st_d = IN_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= IN_WAIT;
    else        st_q <= st_d;
  end

  // The word is written at the same edge that moves the state to IN_ACK,
  // so the acknowledge can only be seen after the capture.
  assign cap    = (st_q == IN_WAIT) && in_req;
  assign in_ack = (st_q == IN_ACK);
  assign done   = (st_q == IN_DONE);

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_req));                   // R2
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && in_req) |=> in_ack);                     // R2
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && !in_req) |=> !in_ack);                   // R2

endmodule

// File: rtl/pphs_out_port.sv
module pphs_out_port
  import pphs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic out_ack,
  output logic out_req,
  output logic done
);

  out_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      OUT_DONE:  if (go)       st_d = OUT_SETUP;
      OUT_SETUP:               st_d = OUT_REQ;
      OUT_REQ:   if (out_ack)  st_d = OUT_REL;
      OUT_REL:   if (!out_ack) st_d = OUT_DONE;
      default:                 st_d = OUT_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= OUT_DONE;
    else        st_q <= st_d;
  end

  assign out_req = (st_q == OUT_REQ);
  assign done    = (st_q == OUT_DONE);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> out_req);                 // R4
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && out_ack) |=> !out_req);                 // R4
  AST_REQ_AFTER_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> !$past(out_ack));                // R4

endmodule

// File: rtl/pphs_store.sv
module pphs_store
  import pphs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              cap,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] out_data
);

  localparam int unsigned SEL_W = $clog2(SLOT_COUNT);

  // Selector value names the slot being filled; the other slot is the source.
  logic [SEL_W-1:0] sel_q;
  logic [DATA_W-1:0] rd [SLOT_COUNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sel_q <= '0;
    else if (go) sel_q <= sel_q + 1'b1;
  end

  for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 q <= '0;
      else if (cap && (sel_q == SEL_W'(i)))        q <= in_data;
    end
    assign rd[i] = q;
  end

  assign out_data = rd[sel_q + 1'b1];

  AST_SOURCE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(out_data));                         // R5
  AST_SEL_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> $past(go));             // R6
  AST_NO_WRITE_AT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && cap));                                      // R7

endmodule

// File: rtl/pphs_buffer.sv
module pphs_buffer
  import pphs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  output logic              in_ack,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_req,
  input  logic              out_ack,
  output logic [DATA_W-1:0] out_data
);

  logic in_done, out_done, cap, go;

  // A phase closes only when both channels have returned to idle.
  assign go = in_done && out_done;

  pphs_in_port u_in (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .in_req (in_req),
    .in_ack (in_ack),
    .cap    (cap),
    .done   (in_done)
  );

  pphs_out_port u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .out_ack (out_ack),
    .out_req (out_req),
    .done    (out_done)
  );

  pphs_store #(.DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .cap      (cap),
    .in_data  (in_data),
    .out_data (out_data)
  );

  AST_BUNDLED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> $stable(out_data));                     // R5
  AST_ACK_WAITS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_done && !out_done) |=> !in_ack);                // R7

endmodule

// File: tb/tb_pphs_buffer.sv
`timescale 1ns/1ps
module tb_pphs_buffer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_req = 1'b0;
  logic       in_ack;
  logic [7:0] in_data = 8'h00;
  logic       out_req;
  logic       out_ack = 1'b0;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pphs_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // R5: data must already be on the wire in the cycle before out_req rises.
  logic       prv_req = 1'b0;
  logic [7:0] prv_dat = 8'h00;
  always @(negedge clk) begin
    if (rst_n && out_req && !prv_req) chk("R5", out_data, prv_dat);
    prv_req = out_req;
    prv_dat = out_data;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_sim();
  end

  function automatic logic [7:0] word_at(input int i);
    if (i == 3) return 8'h00;
    if (i == 4) return 8'hFF;
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_req = 1'b0; out_ack = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", in_ack, 0);
    chk("R1", out_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", in_ack, 0);
    chk("R1", out_req, 0);
    chk("R1", out_data, 0);
  endtask

  task automatic send(input logic [7:0] d, input int hold);
    @(negedge clk);
    in_data = d; in_req = 1'b1;
    do @(negedge clk); while (!in_ack);
    in_data = ~d;  // scramble after capture (R2)
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk("R2", in_ack, 1);
    end
    in_req = 1'b0;
    @(negedge clk);
    chk("R2", in_ack, 0);
  endtask

  task automatic recv(input logic [7:0] exp, input int stall, input string tag);
    do @(negedge clk); while (!out_req);
    chk(tag, out_data, exp);
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      chk("R4", out_req, 1);
    end
    out_ack = 1'b1;
    @(negedge clk);
    chk("R4", out_req, 0);
    @(negedge clk);
    chk("R4", out_req, 0);
    out_ack = 1'b0;
  endtask

  task automatic t_startup();
    do_reset();
    repeat (8) @(negedge clk);
    chk("R3", out_req, 0);
    in_data = 8'h5A; in_req = 1'b1;
    do begin
      @(negedge clk);
      if (!in_ack) chk("R3", out_req, 0);
    end while (!in_ack);
    chk("R3", out_req, 0);
    in_req = 1'b0;
    @(negedge clk);
    chk("R3", out_req, 0);
    recv(8'h5A, 2, "R3");
  endtask

  task automatic t_phase_lock();
    do_reset();
    send(8'h11, 1);
    send(8'h22, 0);            // accepted while 0x11 is on offer
    @(negedge clk);
    in_data = 8'h33; in_req = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7", in_ack, 0);      // consumer stalled: no third acceptance
    chk("R7", out_req, 1);
    fork
      recv(8'h11, 0, "R7");
      begin
        do @(negedge clk); while (!in_ack);
        in_req = 1'b0;
        @(negedge clk);
      end
    join
    recv(8'h22, 1, "R6");
    recv(8'h33, 0, "R6");
    repeat (8) @(negedge clk);
    chk("R7", out_req, 0);     // input idle: no further request
    send(8'h44, 0);
    recv(8'h44, 0, "R6");
  endtask

  task automatic t_stream(input int n);
    do_reset();
    fork
      begin
        for (int i = 0; i < n; i++) begin
          repeat (i % 4) @(negedge clk);
          send(word_at(i), i % 3);
        end
      end
      begin
        for (int i = 0; i < n; i++) begin
          recv(word_at(i), (i * 7) % 5, (i % 2 == 0) ? "R6" : "R8");
        end
      end
    join
  endtask

  task automatic t_reset_mid();
    do_reset();
    send(8'hA5, 0);
    send(8'hC3, 0);
    repeat (2) @(negedge clk);
    chk("R9", out_req, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9", out_req, 0);
    chk("R9", in_ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", out_data, 0);
    repeat (4) @(negedge clk);
    chk("R9", out_req, 0);
    send(8'h7E, 0);
    send(8'h81, 0);
    recv(8'h7E, 0, "R9");
    recv(8'h81, 0, "R9");
  endtask

  initial begin
    t_startup();
    t_phase_lock();
    t_stream(40);
    t_reset_mid();
    repeat (4) @(negedge clk);
    finish_sim();
  end

endmodule